// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a 16-bit virtual address from the processor into a 21-bit physical address. The privilege mode and the instruction/data flag of the current cycle pick one of six space descriptors. The descriptor names one of four shared 64-entry page tables, sets a page limit and may make the space transparent. The top six virtual bits index the chosen page table. The entry found there gives the physical page number, read and write permissions, and the bus the cycle must use: the slow I/O bus or the fast memory bus.

Cycles that fail the page limit or the permission check are aborted and select no bus. Unmapped cycles pass the address through and always use the slow bus. These are cycles made while translation is globally off or in a transparent space. When the top two virtual bits are both set on such a cycle, the top of the I/O region is reached. Each successful mapped cycle marks the entry it used as accessed, and a write also marks it as written. Software loads and inspects both tables through a single-cycle register port with byte-lane enables.

Top module: `vpage_xlate`

## Requirements
- R1: After a synchronous active-low reset, every page table entry and space descriptor reads back 0. With mapping enabled, a read of virtual address 0 in kernel data space is then aborted with the permission flag set and no bus selected.
- R2: Register port: when reg_idx[8]=0 it addresses page table entry reg_idx[7:0], which is {table[1:0], page[5:0]}. When reg_idx[8]=1 it addresses space descriptor reg_idx[2:0]. reg_be[0] enables bits 7:0 and reg_be[1] enables bits 15:8. A descriptor reads back with bits 15:10 and bit 0 as 0. Descriptor indices 6 and 7 read 0 and ignore writes.
- R3: The descriptor index is mode*2 + ispace, with mode 0 kernel, 1 supervisor, 2 user and code 3 treated as user. Descriptor bits: 9:8 table number, 7 transparent, 6:1 maximum page.
- R4: On a mapped cycle, pa = {page number, va[9:0]}. The page number is taken from bits 10:0 of entry {table number, va[15:10]}.
- R5: When mapping is enabled, a page va[15:10] greater than the descriptor's maximum page aborts the cycle with abort_maxpg, also in a transparent space. With mapping disabled nothing aborts.
- R6: On a mapped cycle, a read needs entry bit 12 and a write needs entry bit 13. Otherwise the cycle aborts with abort_perm.
- R7: With map_en=0, or with the transparent bit set, pa equals va zero-extended and io_sel is asserted. In that case pa[17:16] is 2'b11 when va[15:14]=2'b11.
- R8: On a mapped cycle, entry bit 11 = 1 asserts io_sel with io_addr = pa[17:0]. Bit 11 = 0 asserts fast_sel with io_addr = {2'b00, pa[15:0]}.
- R9: A successful mapped cycle sets entry bit 14, and a write also sets bit 15. Other bits are kept. Aborted cycles, internal-register cycles and unmapped cycles leave the entry unchanged. A register write of 0 clears the bits.
- R10: When a register write with both byte lanes hits the entry being marked in the same cycle, the written value is what remains.
- R11: io_sel and fast_sel are never both set, and neither is set while acc_valid is low or the cycle aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_en | input | 1 | Global translation enable |
| acc_valid | input | 1 | An access cycle is presented |
| acc_write | input | 1 | Access is a write |
| acc_ispace | input | 1 | 1 = instruction space, 0 = data space |
| acc_mode | input | 2 | Privilege mode of the access |
| acc_intreg | input | 1 | Access targets an internal register (no marking) |
| acc_va | input | 16 | Virtual address |
| pa | output | 21 | Physical address |
| io_addr | output | 18 | Address presented on the slow bus side |
| io_sel | output | 1 | Cycle goes to the slow I/O bus |
| fast_sel | output | 1 | Cycle goes to the fast memory bus |
| acc_abort | output | 1 | Cycle is aborted |
| abort_maxpg | output | 1 | Page limit exceeded |
| abort_perm | output | 1 | Permission missing |
| reg_en | input | 1 | Register port cycle |
| reg_wr | input | 1 | Register port write |
| reg_idx | input | 9 | Register index |
| reg_be | input | 2 | Byte-lane enables |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (same cycle) |

## Verification
The bench builds the block with its default sizes: four tables of 64 entries, an 11-bit page number and six descriptors. At these sizes the highest page 63 is within reach as a limit, and so are both byte lanes of an entry and the two unused descriptor slots. A 21-bit result is also reached whose top page bits differ from the 18 bits on the slow bus. Usage marking is observed by reading entries back over the register port after single committed cycles. The same path is used for the collision of a write and a marking on one entry.

// File: rtl/vpx_pkg.sv
// Shared widths and record layouts for the paged address translator.
// Assumes a 16-bit virtual address with 64 pages of 1K words each.
package vpx_pkg;
    localparam int VA_W   = 16;
    localparam int OFF_W  = 10;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int TBL_W  = 2;
    localparam int PPN_W  = 11;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int IO_W   = 18;
    localparam int DAT_W  = 16;
    localparam int SPC_CNT = 6;
    localparam int SPC_IW  = 3;
    localparam int RIDX_W  = TBL_W + VPN_W + 1;

    // Page table entry, packed in register bit order.
    typedef struct packed {
        logic             written;
        logic             accessed;
        logic             wr_ok;
        logic             rd_ok;
        logic             slow_bus;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    // Space descriptor, stored without its spare bit 0.
    typedef struct packed {
        logic [TBL_W-1:0] tbl;
        logic             transp;
        logic [VPN_W-1:0] max_vpn;
    } spc_t;

    typedef enum logic [1:0] {
        MODE_KER = 2'd0,
        MODE_SUP = 2'd1,
        MODE_USR = 2'd2,
        MODE_ALT = 2'd3
    } mode_e;
endpackage

// File: rtl/vpx_space_tbl.sv
// Six space descriptors, one per privilege mode and I/D flag.
// Assumes mode code 3 is handled as user mode; indices past the last
// descriptor read as zero and drop writes.
module vpx_space_tbl
    import vpx_pkg::*;
#(
    parameter int CNT = SPC_CNT,
    parameter int IW  = SPC_IW,
    parameter int DW  = DAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    sel_mode,
    input  logic          sel_ispace,
    output spc_t          sel_ent,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [1:0]    wr_be,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    localparam int EW = $bits(spc_t);

    spc_t          ent [CNT];
    logic [1:0]    mode_n;
    logic [IW-1:0] sel_idx;

    // Load descriptors byte lane by byte lane; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CNT; i++) ent[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < CNT; i++) begin
                if (wr_idx == IW'(i)) begin
                    if (wr_be[0]) ent[i][6:0]    <= wr_data[7:1];
                    if (wr_be[1]) ent[i][EW-1:7] <= wr_data[EW:8];
                end
            end
        end
    end

    // Fold the alternate mode code onto user mode, then form the index.
    always_comb begin
        mode_n  = (sel_mode == MODE_ALT) ? MODE_USR : sel_mode;
        sel_idx = {mode_n, sel_ispace};
        sel_ent = '0;
        for (int i = 0; i < CNT; i++)
            if (sel_idx == IW'(i)) sel_ent = ent[i];
    end

    // Software read-back with spare bit and unused upper bits as zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < CNT; i++)
            if (rd_idx == IW'(i)) rd_data = DW'({ent[i], 1'b0});
    end
endmodule

// File: rtl/vpx_page_mem.sv
// Storage for all page tables as one array addressed by {table, page}.
// Read is combinational on two ports (lookup and software). Usage bits
// are set in place; a software write to the same lanes takes precedence.
module vpx_page_mem
    import vpx_pkg::*;
#(
    parameter int AW = TBL_W + VPN_W,
    parameter int DW = DAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_addr,
    output logic [DW-1:0] lk_data,
    input  logic          upd_en,
    input  logic          upd_write,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [1:0]    wr_be,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH   = 1 << AW;
    localparam int ACC_BIT = DW - 2;
    localparam int WRT_BIT = DW - 1;

    logic [DW-1:0] mem [DEPTH];

    // Mark usage first, then apply software write so it wins on overlap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (upd_en) begin
                mem[lk_addr][ACC_BIT] <= 1'b1;
                if (upd_write) mem[lk_addr][WRT_BIT] <= 1'b1;
            end
            if (wr_en) begin
                if (wr_be[0]) mem[wr_addr][7:0]    <= wr_data[7:0];
                if (wr_be[1]) mem[wr_addr][DW-1:8] <= wr_data[DW-1:8];
            end
        end
    end

    // Combinational read ports.
    always_comb lk_data = mem[lk_addr];
    always_comb rd_data = mem[rd_addr];

    // R9
    usage_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !(wr_en && wr_addr == lk_addr)) |=> mem[$past(lk_addr)][ACC_BIT]);

    // R10
    sw_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be == 2'b11) |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/vpx_xlate_core.sv
// Combinational translation: page limit and permission checks, address
// forming for mapped and unmapped cycles, bus choice and marking request.
// Assumes the descriptor and entry inputs already match this cycle.
module vpx_xlate_core
    import vpx_pkg::*;
(
    input  logic             map_en,
    input  logic             valid,
    input  logic             write,
    input  logic [VA_W-1:0]  va,
    input  spc_t             spc,
    input  pte_t             pte,
    output logic [PA_W-1:0]  pa,
    output logic [IO_W-1:0]  io_addr,
    output logic             io_sel,
    output logic             fast_sel,
    output logic             abort,
    output logic             abort_maxpg,
    output logic             abort_perm,
    output logic             mark_ok
);
    logic             mapped;
    logic             slow;
    logic             lim_err;
    logic             prm_err;
    logic [VPN_W-1:0] vpn;
    logic [1:0]       io_hi;

    // Decide whether the cycle is mapped and which check fails.
    always_comb begin
        vpn     = va[VA_W-1:OFF_W];
        mapped  = map_en && !spc.transp;
        lim_err = map_en && (vpn > spc.max_vpn);
        prm_err = mapped && (write ? !pte.wr_ok : !pte.rd_ok);
        abort_maxpg = valid && lim_err;
        abort_perm  = valid && prm_err;
        abort       = abort_maxpg || abort_perm;
        mark_ok     = valid && mapped && !abort;
    end

    // Form the physical and slow-bus addresses and choose the bus.
    always_comb begin
        io_hi = (va[VA_W-1:VA_W-2] == 2'b11) ? 2'b11 : 2'b00;
        if (mapped) begin
            pa      = {pte.ppn, va[OFF_W-1:0]};
            slow    = pte.slow_bus;
            io_addr = slow ? pa[IO_W-1:0] : {2'b00, pa[VA_W-1:0]};
        end else begin
            pa      = PA_W'({io_hi, va});
            slow    = 1'b1;
            io_addr = {io_hi, va};
        end
        io_sel   = valid && !abort && slow;
        fast_sel = valid && !abort && !slow;
    end
endmodule

// File: rtl/vpage_xlate.sv
// Top of the paged virtual address translator: space descriptors, page
// table storage, translation datapath and the software register port.
// Assumes one access and one register operation at most per cycle.
module vpage_xlate
    import vpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_en,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_ispace,
    input  logic [1:0]        acc_mode,
    input  logic              acc_intreg,
    input  logic [VA_W-1:0]   acc_va,
    output logic [PA_W-1:0]   pa,
    output logic [IO_W-1:0]   io_addr,
    output logic              io_sel,
    output logic              fast_sel,
    output logic              acc_abort,
    output logic              abort_maxpg,
    output logic              abort_perm,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [RIDX_W-1:0] reg_idx,
    input  logic [1:0]        reg_be,
    input  logic [DAT_W-1:0]  reg_wdata,
    output logic [DAT_W-1:0]  reg_rdata
);
    localparam int PT_AW = TBL_W + VPN_W;

    spc_t             spc;
    logic [DAT_W-1:0] pte_raw;
    logic [DAT_W-1:0] pt_rd;
    logic [DAT_W-1:0] sp_rd;
    logic [PT_AW-1:0] lk_addr;
    logic             pt_wr;
    logic             sp_wr;
    logic             mark_ok;
    logic             mark_en;

    // Split register port writes between the two tables.
    always_comb begin
        pt_wr   = reg_en && reg_wr && !reg_idx[RIDX_W-1];
        sp_wr   = reg_en && reg_wr &&  reg_idx[RIDX_W-1];
        lk_addr = {spc.tbl, acc_va[VA_W-1:OFF_W]};
        mark_en = mark_ok && !acc_intreg;
        reg_rdata = reg_idx[RIDX_W-1] ? sp_rd : pt_rd;
    end

    vpx_space_tbl u_spc (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_mode   (acc_mode),
        .sel_ispace (acc_ispace),
        .sel_ent    (spc),
        .wr_en      (sp_wr),
        .wr_idx     (reg_idx[SPC_IW-1:0]),
        .wr_be      (reg_be),
        .wr_data    (reg_wdata),
        .rd_idx     (reg_idx[SPC_IW-1:0]),
        .rd_data    (sp_rd)
    );

    vpx_page_mem u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_addr   (lk_addr),
        .lk_data   (pte_raw),
        .upd_en    (mark_en),
        .upd_write (acc_write),
        .wr_en     (pt_wr),
        .wr_addr   (reg_idx[PT_AW-1:0]),
        .wr_be     (reg_be),
        .wr_data   (reg_wdata),
        .rd_addr   (reg_idx[PT_AW-1:0]),
        .rd_data   (pt_rd)
    );

    vpx_xlate_core u_core (
        .map_en      (map_en),
        .valid       (acc_valid),
        .write       (acc_write),
        .va          (acc_va),
        .spc         (spc),
        .pte         (pte_t'(pte_raw)),
        .pa          (pa),
        .io_addr     (io_addr),
        .io_sel      (io_sel),
        .fast_sel    (fast_sel),
        .abort       (acc_abort),
        .abort_maxpg (abort_maxpg),
        .abort_perm  (abort_perm),
        .mark_ok     (mark_ok)
    );

    // R11
    one_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_abort || !acc_valid) |-> (!io_sel && !fast_sel && $onehot0({io_sel, fast_sel})));

    // R8
    fast_hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_sel |-> (io_addr[IO_W-1:IO_W-2] == 2'b00));

    // R7
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !map_en) |-> (io_sel && pa[VA_W-1:0] == acc_va));

    // R5
    no_abort_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !map_en |-> !acc_abort);
endmodule

// File: tb/vpage_xlate_test.sv
module vpage_xlate_test;
    localparam int CLK_PER = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        map_en = 0, acc_valid = 0, acc_write = 0, acc_ispace = 0, acc_intreg = 0;
    logic [1:0]  acc_mode = 0;
    logic [15:0] acc_va = 0;
    logic [20:0] pa;
    logic [17:0] io_addr;
    logic        io_sel, fast_sel, acc_abort, abort_maxpg, abort_perm;
    logic        reg_en = 0, reg_wr = 0;
    logic [8:0]  reg_idx = 0;
    logic [1:0]  reg_be = 0;
    logic [15:0] reg_wdata = 0;
    logic [15:0] reg_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER/2) clk = ~clk;

    vpage_xlate uut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [8:0] idx, logic [1:0] be, logic [15:0] d);
        @(negedge clk);
        reg_en = 1; reg_wr = 1; reg_idx = idx; reg_be = be; reg_wdata = d;
        @(posedge clk); #1;
        reg_en = 0; reg_wr = 0;
    endtask

    task automatic reg_check(string req, logic [8:0] idx, logic [15:0] exp);
        @(negedge clk);
        reg_en = 1; reg_wr = 0; reg_idx = idx; #1;
        check(req, reg_rdata, exp);
        reg_en = 0;
    endtask

    // Present an access and hold it combinationally (no clock edge yet).
    task automatic probe(logic [1:0] m, logic isp, logic wr, logic [15:0] va);
        @(negedge clk);
        acc_valid = 1; acc_mode = m; acc_ispace = isp; acc_write = wr; acc_va = va; #1;
    endtask

    task automatic idle();
        acc_valid = 0; acc_intreg = 0;
    endtask

    // Present an access and let it pass one clock edge.
    task automatic commit(logic [1:0] m, logic isp, logic wr, logic [15:0] va);
        probe(m, isp, wr, va);
        @(posedge clk); #1;
        idle();
    endtask

    task automatic t_reset();
        reg_check("R1 pte", 9'h000, 16'h0000);
        reg_check("R1 spc", 9'h100, 16'h0000);
        map_en = 1;
        probe(2'd0, 0, 0, 16'h0000);
        check("R1 abort", {acc_abort, abort_perm, io_sel, fast_sel}, 4'b1100);
        idle();
    endtask

    task automatic t_regport();
        reg_write(9'h103, 2'b11, 16'hFFFF);
        reg_check("R2 spc mask", 9'h103, 16'h03FE);
        reg_write(9'h106, 2'b11, 16'h03FF);
        reg_check("R2 spc idx6", 9'h106, 16'h0000);
        reg_write(9'h005, 2'b01, 16'h1234);
        reg_check("R2 low lane", 9'h005, 16'h0034);
        reg_write(9'h005, 2'b10, 16'hAB00);
        reg_check("R2 high lane", 9'h005, 16'hAB34);
        reg_write(9'h103, 2'b11, 16'h0000);
    endtask

    task automatic t_translate();
        reg_write(9'h100, 2'b11, 16'h017E);   // kernel D: table 1, max 63
        reg_write(9'h105, 2'b11, 16'h027E);   // user I: table 2, max 63
        reg_write(9'h043, 2'b11, 16'h35A5);   // rw, fast, ppn 5A5
        reg_write(9'h083, 2'b11, 16'h18F1);   // read only, slow, ppn 0F1
        probe(2'd0, 0, 0, 16'h0DF3);
        check("R4 pa", pa, 21'h1695F3);
        check("R8 fast", {fast_sel, io_sel, io_addr}, {2'b10, 18'h095F3});
        idle();
        probe(2'd2, 1, 0, 16'h0C05);
        check("R8 slow", {io_sel, fast_sel, io_addr}, {2'b10, 18'h3C405});
        check("R4 pa slow", pa, 21'h03C405);
        idle();
        probe(2'd3, 1, 0, 16'h0C05);
        check("R3 mode3 as user", pa, 21'h03C405);
        idle();
        probe(2'd0, 1, 0, 16'h0C05);
        check("R3 kernel I separate", acc_abort, 1'b1);
        idle();
    endtask

    task automatic t_maxpage();
        reg_write(9'h102, 2'b11, 16'h0104);   // super D: table 1, max 2
        probe(2'd1, 0, 0, 16'h0C00);
        check("R5 over limit", {abort_maxpg, acc_abort}, 2'b11);
        idle();
        probe(2'd1, 0, 0, 16'h0800);
        check("R5 at limit", {abort_maxpg, abort_perm}, 2'b01);
        idle();
        reg_write(9'h103, 2'b11, 16'h0084);   // super I: transparent, max 2
        probe(2'd1, 1, 0, 16'h0C00);
        check("R5 transparent limit", abort_maxpg, 1'b1);
        map_en = 0; #1;
        check("R5 disabled", {acc_abort, io_sel}, 2'b01);
        idle(); map_en = 1;
    endtask

    task automatic t_perm();
        probe(2'd2, 1, 1, 16'h0C05);
        check("R6 write to read-only", {abort_perm, io_sel}, 2'b10);
        idle();
        probe(2'd0, 0, 1, 16'h0C00);
        check("R6 write allowed", {acc_abort, fast_sel}, 2'b01);
        idle();
        reg_write(9'h044, 2'b11, 16'h2010);   // write only, fast, ppn 010
        probe(2'd0, 0, 0, 16'h1000);
        check("R6 read of write-only", abort_perm, 1'b1);
        idle();
        probe(2'd0, 0, 1, 16'h1000);
        check("R6 write-only write", {acc_abort, pa}, {1'b0, 21'h004000});
        idle();
    endtask

    task automatic t_unmapped();
        map_en = 0;
        probe(2'd0, 0, 0, 16'hC123);
        check("R7 io top", {pa, io_addr}, {21'h03C123, 18'h3C123});
        check("R7 bus", {io_sel, fast_sel}, 2'b10);
        idle();
        probe(2'd0, 0, 0, 16'h8123);
        check("R7 no force", pa, 21'h008123);
        idle();
        map_en = 1;
        reg_write(9'h103, 2'b11, 16'h00FE);   // super I: transparent, max 63
        probe(2'd1, 1, 0, 16'hF000);
        check("R7 transparent", {io_sel, pa}, {1'b1, 21'h03F000});
        idle();
    endtask

    task automatic t_usage();
        reg_write(9'h045, 2'b11, 16'h3022);
        commit(2'd0, 0, 0, 16'h1400);
        reg_check("R9 accessed", 9'h045, 16'h7022);
        commit(2'd0, 0, 1, 16'h1400);
        reg_check("R9 written", 9'h045, 16'hF022);
        commit(2'd0, 0, 0, 16'h1400);
        reg_check("R9 kept", 9'h045, 16'hF022);
        reg_write(9'h046, 2'b11, 16'h1001);
        commit(2'd0, 0, 1, 16'h1800);
        reg_check("R9 abort no mark", 9'h046, 16'h1001);
        @(negedge clk); acc_intreg = 1;
        acc_valid = 1; acc_mode = 0; acc_ispace = 0; acc_write = 0; acc_va = 16'h1800;
        @(posedge clk); #1; idle();
        reg_check("R9 intreg no mark", 9'h046, 16'h1001);
        map_en = 0;
        commit(2'd0, 0, 0, 16'h1800);
        map_en = 1;
        reg_check("R9 unmapped no mark", 9'h046, 16'h1001);
        reg_write(9'h045, 2'b11, 16'h3022);
        reg_check("R9 software clear", 9'h045, 16'h3022);
    endtask

    task automatic t_collide();
        reg_write(9'h047, 2'b11, 16'h3033);
        @(negedge clk);
        acc_valid = 1; acc_mode = 0; acc_ispace = 0; acc_write = 1; acc_va = 16'h1C00;
        reg_en = 1; reg_wr = 1; reg_idx = 9'h047; reg_be = 2'b11; reg_wdata = 16'h3044;
        @(posedge clk); #1;
        idle(); reg_en = 0; reg_wr = 0;
        reg_check("R10 write wins", 9'h047, 16'h3044);
        commit(2'd0, 0, 0, 16'h1C00);
        reg_check("R10 later mark", 9'h047, 16'h7044);
    endtask

    task automatic t_gate();
        @(negedge clk);
        acc_valid = 0; acc_mode = 0; acc_ispace = 0; acc_write = 0; acc_va = 16'h0DF3; #1;
        check("R11 idle no select", {io_sel, fast_sel}, 2'b00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_regport();
        t_translate();
        t_maxpage();
        t_perm();
        t_unmapped();
        t_usage();
        t_collide();
        t_gate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act %h exp %h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule